// File: doc/BRIEF.md
# Power domain switch sequencer

This block brings one switchable power domain up or down. A one-cycle `req_on` or `req_off` pulse starts a fixed sequence that changes the domain's control word one field per clock cycle. Between certain steps the sequence waits for acknowledges from the domain: two power-switch status inputs, and a group of SRAM power-down acknowledges. The group's width is a parameter and may be zero. The bring-down order mirrors the bring-up order.

Every wait is bounded by a cycle limit. When a wait runs out, the sequence stops and leaves the control word as it is. It raises a timeout pulse and then accepts either request again. The full control word is presented on `ctrl_word` for readback. One-cycle pulses report completion, timeout and rejected requests, and `busy` is high while a sequence runs.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset, `ctrl_word` is 0xF12: bit 0 (active-low reset release) = 0, bit 1 (isolation) = 1, bit 2 (primary switch) = 0, bit 3 (secondary switch) = 0, bit 4 (clock disable) = 1, bits 11:8 (SRAM power-down) = all 1. `busy`, `done`, `err_timeout` and `req_ignored` are 0.
- R2: On an accepted `req_on`, `ctrl_word` takes these values in this order: 0xF16 (primary on), 0xF1E (secondary on), then, once both `pwr_ack` and `pwr_ack2` are 1, 0xF0E (clock enabled), 0xF0C (isolation off), 0xF0D (reset released) and 0x00D (SRAM powered up).
- R3: Power-on ends with a one-cycle `done` only after a clock edge at which every `sram_ack` bit is 0. When all acknowledges answer at once, `done` is seen 7 cycles after the accepting edge (counting that edge as 1).
- R4: On an accepted `req_off` from the on state, `ctrl_word` takes these values in this order: 0xF0D (SRAM down), then, once every `sram_ack` bit is 1, 0xF0F (isolated), 0xF0E (reset held), 0xF1E (clock off), 0xF1A (primary off) and 0xF12 (secondary off).
- R5: Power-off ends with a one-cycle `done` only after a clock edge at which both power-status inputs are 0. With prompt acknowledges, this takes 7 cycles.
- R6: At most one field of `ctrl_word` changes per cycle. The SRAM power-down group counts as one field.
- R7: A wait that is unsatisfied for TIMEOUT_CYC clock edges aborts. `err_timeout` pulses for one cycle, `done` is not raised, `busy` drops and `ctrl_word` holds its value. After an abort, either request is accepted and restarts its sequence from the held word.
- R8: A request that arrives while `busy` is high is ignored: `req_ignored` pulses in the following cycle, and the running sequence and its timing are unchanged.
- R9: A request for the state the domain is already in raises `done` in the next cycle, leaves `ctrl_word` unchanged and does not raise `busy`.
- R10: With ACK_W = 0, the SRAM waits pass at their first edge whatever `sram_ack` carries. Power-on and power-off still take 7 cycles.
- R11: `busy` is 1 from the accepting edge until the completing or aborting edge, and `done` is never 1 while `busy` is 1.
- R12: `req_on` and `req_off` together while idle are ignored: `req_ignored` pulses and `ctrl_word` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_on | input | 1 | Power-up request pulse |
| req_off | input | 1 | Power-down request pulse |
| pwr_ack | input | 1 | Primary power-switch status |
| pwr_ack2 | input | 1 | Secondary power-switch status |
| sram_ack | input | max(ACK_W,1) | SRAM power-down acknowledges (1 = powered down); unused when ACK_W = 0 |
| ctrl_word | output | 8+SRAM_LINES | Domain control word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | One-cycle timeout-abort pulse |
| req_ignored | output | 1 | One-cycle rejected-request pulse |

## Verification
The main instance is built with ACK_W = 2 and TIMEOUT_CYC = 20. The short limit lets the bench hold an acknowledge frozen until the abort at edge 22, and then resume from the held control word. A second instance with ACK_W = 0 has its SRAM acknowledge input tied high. This shows that the zero-width handshake really bypasses the SRAM waits rather than waiting on a constant. Frozen acknowledges also stretch both the power-on and power-off waits, so the bench can check that completion waits for the right input.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int RSTB_BIT   = 0;
  localparam int ISO_BIT    = 1;
  localparam int PON_BIT    = 2;
  localparam int PON2_BIT   = 3;
  localparam int CLKDIS_BIT = 4;
  localparam int SRAM_LSB   = 8;

  typedef enum logic [4:0] {
    S_IDLE_OFF, S_IDLE_ON, S_IDLE_ERR,
    S_ON_SW2, S_ON_WPWR, S_ON_ISO, S_ON_RST, S_ON_SRAM, S_ON_WSRAM,
    S_OFF_WSRAM, S_OFF_RST, S_OFF_CLK, S_OFF_SW1, S_OFF_SW2, S_OFF_WPWR
  } seq_state_e;
endpackage

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (waiting && !expired) cnt_q <= cnt_q + 1'b1;
    else cnt_q <= '0;
  end

  assign expired = waiting && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
  import pds_pkg::*;
#(
  parameter int ACK_W      = 4,
  parameter int ACK_PW     = 4,
  parameter int SRAM_LINES = 4,
  parameter int CW_W       = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_on,
  input  logic              req_off,
  input  logic              pwr_ack,
  input  logic              pwr_ack2,
  input  logic [ACK_PW-1:0] sram_ack,
  input  logic              expired,
  output logic [CW_W-1:0]   ctrl_q,
  output logic              waiting,
  output logic              seq_done,
  output logic              seq_abort,
  output logic              req_drop,
  output logic              busy
);
  seq_state_e st_q;
  logic is_idle, wait_ok, one_req;

  function automatic logic [CW_W-1:0] off_word();
    logic [CW_W-1:0] w;
    w = '0;
    w[ISO_BIT] = 1'b1;
    w[CLKDIS_BIT] = 1'b1;
    w[CW_W-1:SRAM_LSB] = '1;
    return w;
  endfunction

  // A zero-width acknowledge group is always satisfied.
  function automatic logic sram_all_low(input logic [ACK_PW-1:0] a);
    return (ACK_W == 0) ? 1'b1 : ~|a;
  endfunction

  function automatic logic sram_all_high(input logic [ACK_PW-1:0] a);
    return (ACK_W == 0) ? 1'b1 : &a;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE_OFF;
      ctrl_q <= off_word();
    end else begin
      case (st_q)
        S_IDLE_OFF, S_IDLE_ON, S_IDLE_ERR: begin
          if (req_on && !req_off && st_q != S_IDLE_ON) begin
            ctrl_q[PON_BIT] <= 1'b1;
            st_q <= S_ON_SW2;
          end else if (req_off && !req_on && st_q != S_IDLE_OFF) begin
            ctrl_q[CW_W-1:SRAM_LSB] <= '1;
            st_q <= S_OFF_WSRAM;
          end
        end
        S_ON_SW2: begin ctrl_q[PON2_BIT] <= 1'b1; st_q <= S_ON_WPWR; end
        S_ON_WPWR: begin
          if (wait_ok) begin ctrl_q[CLKDIS_BIT] <= 1'b0; st_q <= S_ON_ISO; end
          else if (expired) st_q <= S_IDLE_ERR;
        end
        S_ON_ISO:  begin ctrl_q[ISO_BIT] <= 1'b0;  st_q <= S_ON_RST; end
        S_ON_RST:  begin ctrl_q[RSTB_BIT] <= 1'b1; st_q <= S_ON_SRAM; end
        S_ON_SRAM: begin ctrl_q[CW_W-1:SRAM_LSB] <= '0; st_q <= S_ON_WSRAM; end
        S_ON_WSRAM: begin
          if (wait_ok) st_q <= S_IDLE_ON;
          else if (expired) st_q <= S_IDLE_ERR;
        end
        S_OFF_WSRAM: begin
          if (wait_ok) begin ctrl_q[ISO_BIT] <= 1'b1; st_q <= S_OFF_RST; end
          else if (expired) st_q <= S_IDLE_ERR;
        end
        S_OFF_RST: begin ctrl_q[RSTB_BIT] <= 1'b0;   st_q <= S_OFF_CLK; end
        S_OFF_CLK: begin ctrl_q[CLKDIS_BIT] <= 1'b1; st_q <= S_OFF_SW1; end
        S_OFF_SW1: begin ctrl_q[PON_BIT] <= 1'b0;    st_q <= S_OFF_SW2; end
        S_OFF_SW2: begin ctrl_q[PON2_BIT] <= 1'b0;   st_q <= S_OFF_WPWR; end
        S_OFF_WPWR: begin
          if (wait_ok) st_q <= S_IDLE_OFF;
          else if (expired) st_q <= S_IDLE_ERR;
        end
        default: st_q <= S_IDLE_ERR;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      S_ON_WPWR:   wait_ok = pwr_ack && pwr_ack2;
      S_ON_WSRAM:  wait_ok = sram_all_low(sram_ack);
      S_OFF_WSRAM: wait_ok = sram_all_high(sram_ack);
      S_OFF_WPWR:  wait_ok = !pwr_ack && !pwr_ack2;
      default:     wait_ok = 1'b0;
    endcase
  end

  assign is_idle = (st_q == S_IDLE_OFF) || (st_q == S_IDLE_ON) || (st_q == S_IDLE_ERR);
  assign waiting = (st_q == S_ON_WPWR) || (st_q == S_ON_WSRAM) ||
                   (st_q == S_OFF_WSRAM) || (st_q == S_OFF_WPWR);
  assign one_req = req_on ^ req_off;
  assign busy    = !is_idle;

  assign seq_done = (is_idle && one_req &&
                     ((req_on && st_q == S_IDLE_ON) || (req_off && st_q == S_IDLE_OFF))) ||
                    (wait_ok && (st_q == S_ON_WSRAM || st_q == S_OFF_WPWR));
  assign seq_abort = waiting && !wait_ok && expired;
  assign req_drop  = is_idle ? (req_on && req_off) : (req_on || req_off);
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq #(
  parameter int ACK_W       = 4,
  parameter int SRAM_LINES  = 4,
  parameter int TIMEOUT_CYC = 1000,
  localparam int ACK_PW     = (ACK_W > 0) ? ACK_W : 1,
  localparam int CW_W       = 8 + SRAM_LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_on,
  input  logic              req_off,
  input  logic              pwr_ack,
  input  logic              pwr_ack2,
  input  logic [ACK_PW-1:0] sram_ack,
  output logic [CW_W-1:0]   ctrl_word,
  output logic              busy,
  output logic              done,
  output logic              err_timeout,
  output logic              req_ignored
);
  logic waiting, expired, seq_done, seq_abort, req_drop;

  pds_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .waiting(waiting), .expired(expired)
  );

  pds_fsm #(
    .ACK_W(ACK_W), .ACK_PW(ACK_PW), .SRAM_LINES(SRAM_LINES), .CW_W(CW_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
    .pwr_ack(pwr_ack), .pwr_ack2(pwr_ack2), .sram_ack(sram_ack),
    .expired(expired), .ctrl_q(ctrl_word), .waiting(waiting),
    .seq_done(seq_done), .seq_abort(seq_abort), .req_drop(req_drop), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      err_timeout <= 1'b0;
      req_ignored <= 1'b0;
    end else begin
      done        <= seq_done;
      err_timeout <= seq_abort;
      req_ignored <= req_drop;
    end
  end
endmodule

// File: rtl/pwr_domain_seq_chk.sv
module pwr_domain_seq_chk #(
  parameter int ACK_W  = 4,
  parameter int ACK_PW = 4,
  parameter int CW_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CW_W-1:0]   ctrl_word,
  input logic              busy,
  input logic              done,
  input logic              err_timeout,
  input logic              pwr_ack,
  input logic              pwr_ack2,
  input logic [ACK_PW-1:0] sram_ack,
  input logic              seq_done,
  input logic              seq_abort
);
  logic [CW_W-1:0] prev_word;
  logic            seen_clk;
  logic [5:0]      fld_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_word <= ctrl_word;
      seen_clk  <= 1'b0;
    end else begin
      prev_word <= ctrl_word;
      seen_clk  <= 1'b1;
    end
  end

  assign fld_chg = {ctrl_word[CW_W-1:8] != prev_word[CW_W-1:8],
                    ctrl_word[4] != prev_word[4], ctrl_word[3] != prev_word[3],
                    ctrl_word[2] != prev_word[2], ctrl_word[1] != prev_word[1],
                    ctrl_word[0] != prev_word[0]};

  // R6: one field per cycle
  p_one_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seen_clk |-> ($countones(fld_chg) <= 1));

  // R2: isolation lifts only with both switches on and clock running
  p_iso_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_word[1]) |-> (ctrl_word[2] && ctrl_word[3] && !ctrl_word[4]));

  // R4: primary switch drops only after SRAM down and clock gated
  p_switch_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_word[2]) |-> (ctrl_word[4] && ctrl_word[1] && (&ctrl_word[CW_W-1:8])));

  // R3: power-on completion follows all SRAM acks low
  p_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(busy) && ctrl_word[2]) |-> ((ACK_W == 0) || $past(~|sram_ack)));

  // R5: power-off completion follows both power acks low
  p_off_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(busy) && !ctrl_word[2]) |-> $past(!pwr_ack && !pwr_ack2));

  // R7: abort yields error pulse, never done
  p_abort_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> (err_timeout && !done && !busy));

  // R11: done and busy exclusive; completion strobe registers into done
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> done);
endmodule

bind pwr_domain_seq pwr_domain_seq_chk #(
  .ACK_W(ACK_W), .ACK_PW(ACK_PW), .CW_W(CW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .busy(busy), .done(done),
  .err_timeout(err_timeout), .pwr_ack(pwr_ack), .pwr_ack2(pwr_ack2),
  .sram_ack(sram_ack), .seq_done(seq_done), .seq_abort(seq_abort)
);

// File: tb/pwr_domain_seq_test.sv
`timescale 1ns/1ps
module pwr_domain_seq_test;
  localparam int AW = 2;
  localparam int TO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_on = 1'b0, req_off = 1'b0;
  logic pwr_ack = 1'b0, pwr_ack2 = 1'b0;
  logic [AW-1:0] sram_ack = '1;
  logic [11:0] ctrl_word;
  logic busy, done, err_timeout, req_ignored;

  logic zreq_on = 1'b0, zreq_off = 1'b0;
  logic zp_ack = 1'b0, zp_ack2 = 1'b0;
  logic [11:0] z_word;
  logic z_busy, z_done, z_err, z_ign;

  pwr_domain_seq #(.ACK_W(AW), .SRAM_LINES(4), .TIMEOUT_CYC(TO)) uut (
    .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
    .pwr_ack(pwr_ack), .pwr_ack2(pwr_ack2), .sram_ack(sram_ack),
    .ctrl_word(ctrl_word), .busy(busy), .done(done),
    .err_timeout(err_timeout), .req_ignored(req_ignored)
  );

  pwr_domain_seq #(.ACK_W(0), .SRAM_LINES(4), .TIMEOUT_CYC(TO)) uut_z (
    .clk(clk), .rst_n(rst_n), .req_on(zreq_on), .req_off(zreq_off),
    .pwr_ack(zp_ack), .pwr_ack2(zp_ack2), .sram_ack(1'b1),
    .ctrl_word(z_word), .busy(z_busy), .done(z_done),
    .err_timeout(z_err), .req_ignored(z_ign)
  );

  int n_vec = 0, n_bad = 0;
  logic [11:0] exp_q[$];
  logic [11:0] prev_word;
  logic mon_en = 1'b0;
  logic frz_pwr = 1'b0, frz_sram = 1'b0;
  logic finished = 1'b0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Responder: acknowledges follow the control word half a cycle later.
  initial forever begin
    @(negedge clk);
    if (!frz_pwr) begin pwr_ack = ctrl_word[2]; pwr_ack2 = ctrl_word[3]; end
    if (!frz_sram) sram_ack = {AW{&ctrl_word[11:8]}};
    zp_ack = z_word[2]; zp_ack2 = z_word[3];
  end

  // Scoreboard monitor: every change of the word must match the queue head.
  initial forever begin
    @(negedge clk);
    if (mon_en && ctrl_word !== prev_word) begin
      if (exp_q.size() == 0)
        check(1'b0, "R6 unexpected word change", int'(ctrl_word), int'(prev_word));
      else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        check(ctrl_word === e, "R2/R4 word order", int'(ctrl_word), int'(e));
      end
      prev_word = ctrl_word;
    end
  end

  task automatic push_on_words();
    exp_q.push_back(12'hF16); exp_q.push_back(12'hF1E); exp_q.push_back(12'hF0E);
    exp_q.push_back(12'hF0C); exp_q.push_back(12'hF0D); exp_q.push_back(12'h00D);
  endtask

  task automatic push_off_words();
    exp_q.push_back(12'hF0D); exp_q.push_back(12'hF0F); exp_q.push_back(12'hF0E);
    exp_q.push_back(12'hF1E); exp_q.push_back(12'hF1A); exp_q.push_back(12'hF12);
  endtask

  // Pulse ends at the negedge after the accepting edge (cycle 1).
  task automatic pulse(input bit on, input bit off);
    @(negedge clk); req_on = on; req_off = off;
    @(negedge clk); req_on = 1'b0; req_off = 1'b0;
  endtask

  task automatic zpulse(input bit on);
    @(negedge clk); zreq_on = on; zreq_off = !on;
    @(negedge clk); zreq_on = 1'b0; zreq_off = 1'b0;
  endtask

  task automatic run_until(input int start, input int maxn, output int n,
                           output logic sd, output logic se);
    n = start; sd = done; se = err_timeout;
    while (!sd && !se && n < maxn) begin
      @(negedge clk); n++; sd = done; se = err_timeout;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic sd, se;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(ctrl_word === 12'hF12, "R1 reset word", int'(ctrl_word), 'hF12);
    check(!busy && !done && !err_timeout && !req_ignored, "R1 reset flags",
          {busy, done, err_timeout, req_ignored}, 0);
    prev_word = ctrl_word; mon_en = 1'b1;

    // R9: off while off
    pulse(1'b0, 1'b1);
    check(done && !busy && ctrl_word === 12'hF12, "R9 same-state done",
          {done, busy}, 2);

    // R2 R3 R11: power on, prompt acks
    push_on_words();
    pulse(1'b1, 1'b0);
    check(busy === 1'b1, "R11 busy after accept", busy, 1);
    run_until(1, 40, n, sd, se);
    check(sd && n == 7, "R3 on done cycle", n, 7);
    check(!busy, "R11 busy cleared", busy, 0);
    @(negedge clk);
    check(!done, "R3 done one cycle", done, 0);
    check(exp_q.size() == 0, "R2 on words consumed", exp_q.size(), 0);

    // R12: both requests in idle
    pulse(1'b1, 1'b1);
    check(req_ignored && !done && ctrl_word === 12'h00D, "R12 both ignored",
          {req_ignored, done}, 2);

    // R4 R5 R8: power off with an extra request in cycle 2
    push_off_words();
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    check(req_ignored === 1'b1, "R8 busy request flagged", req_ignored, 1);
    run_until(3, 40, n, sd, se);
    check(sd && n == 7, "R5 off done cycle", n, 7);
    check(exp_q.size() == 0, "R4 off words consumed", exp_q.size(), 0);

    // R3: power-on held until SRAM acks drop
    frz_sram = 1'b1;
    push_on_words();
    pulse(1'b1, 1'b0);
    repeat (9) @(negedge clk);
    check(!done && busy, "R3 waits on sram ack", {done, busy}, 1);
    frz_sram = 1'b0;
    run_until(10, 20, n, sd, se);
    check(sd && !se && ctrl_word === 12'h00D, "R3 done after sram ack", n, 12);

    // R5: power-off held until power acks drop
    frz_pwr = 1'b1;
    push_off_words();
    pulse(1'b0, 1'b1);
    repeat (9) @(negedge clk);
    check(!done && busy, "R5 waits on power ack", {done, busy}, 1);
    frz_pwr = 1'b0;
    run_until(10, 20, n, sd, se);
    check(sd && !se && ctrl_word === 12'hF12, "R5 done after power ack", n, 12);

    // R7: timeout on power-on acknowledge wait (acks frozen at 0)
    frz_pwr = 1'b1;
    repeat (2) @(negedge clk);
    exp_q.push_back(12'hF16); exp_q.push_back(12'hF1E);
    pulse(1'b1, 1'b0);
    run_until(1, 60, n, sd, se);
    check(se && !sd && n == TO + 2, "R7 abort cycle", n, TO + 2);
    check(!busy && ctrl_word === 12'hF1E, "R7 word held", int'(ctrl_word), 'hF1E);
    @(negedge clk);
    check(!err_timeout, "R7 error one cycle", err_timeout, 0);
    frz_pwr = 1'b0;
    repeat (2) @(negedge clk);
    exp_q.push_back(12'hF0E); exp_q.push_back(12'hF0C);
    exp_q.push_back(12'hF0D); exp_q.push_back(12'h00D);
    pulse(1'b1, 1'b0);
    run_until(1, 40, n, sd, se);
    check(sd && n == 7, "R7 restart after abort", n, 7);
    check(exp_q.size() == 0, "R7 restart words", exp_q.size(), 0);

    // R10: zero-width SRAM handshake, sram_ack tied high
    zpulse(1'b1);
    n = 1;
    while (!z_done && n < 30) begin @(negedge clk); n++; end
    check(z_done && n == 7 && z_word === 12'h00D, "R10 on without sram wait", n, 7);
    zpulse(1'b0);
    n = 1;
    while (!z_done && n < 30) begin @(negedge clk); n++; end
    check(z_done && n == 7 && z_word === 12'hF12, "R10 off without sram wait", n, 7);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule